// File: doc/BRIEF.md
# Variable Bit-Field Isolate Unit

This unit pulls a bit field of variable length out of a 48-bit top-of-stack word and returns it right-justified, with every bit above the field cleared. Bit 0 of a word is its most significant bit, carried on `a_in[47]`, and bit 47 is on `a_in[0]`. The field begins at a position given by a 3-bit character pointer and a 3-bit bit pointer, where one character is 6 bits wide. The length comes from a 6-bit instruction variant. When a field runs past the end of the word, it continues from bit 0.

The surrounding sequencer presents the word, the two pointers and the variant, and pulses `start`. The unit raises `busy` for a number of clock cycles that models the shift time and reports that number. It then pulses `done` and presents the new word and the updated pointers on registered outputs. After an operation the character pointer has moved past the field and the bit pointer is cleared.

Top module: `field_isolate`

## Requirements
- R1: While `rst` is high at a clock edge, `busy`, `done`, `a_out`, `g_out`, `h_out` and `cycles_out` all become 0.
- R2: The field begins at bit position g_in*6 + h, counted from the most significant bit (bit 0 = `a_in[47]`).
- R3: The field length is chars*6 - trim, where chars = `variant[5:3]` and trim = `variant[2:0]`. If trim is not smaller than chars*6, the length is zero and the result word is all zeros.
- R4: When start + length <= 48, `a_out` holds the selected bits in their original order in its low `length` bits, and all higher bits are 0.
- R5: When start + length > 48, the field takes bits from the start position to bit 47, followed by bits from bit 0 onward. The tail piece sits above the wrapped piece in the right-justified result.
- R6: If chars = 0, the operation is a no-op. `busy` stays low, `done` pulses in the cycle after `start`, `a_out`/`g_out`/`h_out` equal `a_in`/`g_in`/`h_in`, and `cycles_out` is 0.
- R7: After an operation with chars > 0, `g_out` = (g_in + chars) mod 8 and `h_out` = 0.
- R8: From the cycle after an accepted `start`, `cycles_out` = chars + trim + g_in + h, using the pointer values given with `start`.
- R9: For chars > 0, `busy` is high for exactly `cycles_out` cycles starting the cycle after `start`. `done` is high for one cycle, right after `busy` falls, and `busy` and `done` are never high together. A `start` in the `done` cycle is accepted.
- R10: A `start` while `busy` is high is ignored. The outputs and the running operation are unaffected.
- R11: An `h_in` value of 6 or 7 is treated as 5, both for the start position and for the cycle count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| variant | input | 6 | [5:3] whole characters, [2:0] bit trim |
| a_in | input | 48 | Source word (bit 0 on a_in[47]) |
| g_in | input | 3 | Character pointer |
| h_in | input | 3 | Bit-in-character pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| a_out | output | 48 | Resulting word |
| g_out | output | 3 | Updated character pointer |
| h_out | output | 3 | Updated bit pointer |
| cycles_out | output | 5 | Reported cycle count of the last accepted operation |

## Verification
Two events can land in the same clock cycle. One is a finishing operation raising `done`. The other is a fresh `start`, which may arrive either in that `done` cycle or in the last `busy` cycle. The bench drives a second `start` exactly in the `done` cycle, and there it must launch a new run. It also drives a `start` with different data partway through a run, and that one must change nothing. A behavioural model built from integers and bit loops predicts every output, and the bench compares against it on each clock. Both provoked coincidences are therefore judged against the model's view of which start was taken.

// File: rtl/fisol_pkg.sv
package fisol_pkg;
  localparam int WORD_W  = 48;
  localparam int CHAR_W  = 6;
  localparam int PTR_W   = 3;
  localparam int NCH_W   = 3;
  localparam int TRIM_W  = 3;
  localparam int VAR_W   = NCH_W + TRIM_W;
  localparam int POS_W   = $clog2(WORD_W);
  localparam int LEN_W   = POS_W + 1;
  localparam int MAX_CYC = (2**NCH_W - 1) + (2**TRIM_W - 1) + (2**PTR_W - 1) + (CHAR_W - 1);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  typedef struct packed {
    logic [POS_W-1:0] start_pos;
    logic [LEN_W-1:0] len;
    logic [CNT_W-1:0] cycles;
    logic [PTR_W-1:0] g_next;
    logic             nop;
  } fisol_dec_t;
endpackage

// File: rtl/fisol_decode.sv
module fisol_decode
  import fisol_pkg::*;
(
  input  logic [VAR_W-1:0] variant,
  input  logic [PTR_W-1:0] g_in,
  input  logic [PTR_W-1:0] h_in,
  output fisol_dec_t       dec
);
  logic [NCH_W-1:0]  nchar;
  logic [TRIM_W-1:0] trim;
  logic [PTR_W-1:0]  h_eff;
  logic [LEN_W-1:0]  raw_bits;

  always_comb begin
    nchar    = variant[VAR_W-1:TRIM_W];
    trim     = variant[TRIM_W-1:0];
    // bit pointer beyond the last bit of a character saturates
    h_eff    = (h_in > PTR_W'(CHAR_W - 1)) ? PTR_W'(CHAR_W - 1) : h_in;
    raw_bits = LEN_W'(nchar) * LEN_W'(CHAR_W);

    dec.start_pos = POS_W'(g_in) * POS_W'(CHAR_W) + POS_W'(h_eff);
    dec.len       = (raw_bits > LEN_W'(trim)) ? raw_bits - LEN_W'(trim) : '0;
    dec.cycles    = CNT_W'(nchar) + CNT_W'(trim) + CNT_W'(g_in) + CNT_W'(h_eff);
    dec.g_next    = g_in + PTR_W'(nchar);
    dec.nop       = (nchar == '0);
  end
endmodule

// File: rtl/fisol_extract.sv
module fisol_extract
  import fisol_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [POS_W-1:0]  start_pos,
  input  logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] field
);
  logic [2*WORD_W-1:0] doubled;
  logic [2*WORD_W-1:0] shifted;
  logic [WORD_W-1:0]   rotated;
  logic [LEN_W-1:0]    drop;

  always_comb begin
    // circular rotate: start bit lands on the MSB, wrap-around follows below it
    doubled = {word, word};
    shifted = doubled << start_pos;
    rotated = shifted[2*WORD_W-1:WORD_W];
    drop    = LEN_W'(WORD_W) - len;
    field   = rotated >> drop;
  end
endmodule

// File: rtl/fisol_seq.sv
module fisol_seq
  import fisol_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             nop,
  input  logic [CNT_W-1:0] cycles,
  output logic             accept,
  output logic             finish,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  assign accept = start && !busy;
  assign finish = busy && (remain == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else begin
      done <= finish || (accept && nop);
      if (accept && !nop) begin
        busy   <= 1'b1;
        remain <= cycles;
      end else if (finish) begin
        busy   <= 1'b0;
        remain <= '0;
      end else if (busy) begin
        remain <= remain - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/field_isolate.sv
module field_isolate
  import fisol_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [VAR_W-1:0]  variant,
  input  logic [WORD_W-1:0] a_in,
  input  logic [PTR_W-1:0]  g_in,
  input  logic [PTR_W-1:0]  h_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] a_out,
  output logic [PTR_W-1:0]  g_out,
  output logic [PTR_W-1:0]  h_out,
  output logic [CNT_W-1:0]  cycles_out
);
  fisol_dec_t        dec;
  logic [WORD_W-1:0] field;
  logic              accept;
  logic              finish;
  logic [WORD_W-1:0] pend_a;
  logic [PTR_W-1:0]  pend_g;

  fisol_decode u_dec (
    .variant (variant),
    .g_in    (g_in),
    .h_in    (h_in),
    .dec     (dec)
  );

  fisol_extract u_ext (
    .word      (a_in),
    .start_pos (dec.start_pos),
    .len       (dec.len),
    .field     (field)
  );

  fisol_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .nop    (dec.nop),
    .cycles (dec.cycles),
    .accept (accept),
    .finish (finish),
    .busy   (busy),
    .done   (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_out      <= '0;
      g_out      <= '0;
      h_out      <= '0;
      cycles_out <= '0;
      pend_a     <= '0;
      pend_g     <= '0;
    end else begin
      if (accept) begin
        if (dec.nop) begin
          cycles_out <= '0;
          a_out      <= a_in;
          g_out      <= g_in;
          h_out      <= h_in;
        end else begin
          cycles_out <= dec.cycles;
          pend_a     <= field;
          pend_g     <= dec.g_next;
        end
      end
      if (finish) begin
        a_out <= pend_a;
        g_out <= pend_g;
        h_out <= '0;
      end
    end
  end
endmodule

// File: rtl/field_isolate_chk.sv
module field_isolate_chk
  import fisol_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [NCH_W-1:0]  var_chars,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] a_out,
  input logic [PTR_W-1:0]  g_out,
  input logic [PTR_W-1:0]  h_out,
  input logic [CNT_W-1:0]  cycles_out
);
  logic [CNT_W:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_nop_fast_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && var_chars == '0) |=> (done && !busy && cycles_out == '0));

  p_launch_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && var_chars != '0) |=> (busy && !done));

  p_h_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (done && $past(busy)) |-> (h_out == '0));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(a_out) && $stable(g_out) && $stable(cycles_out)));

  p_run_len_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == (CNT_W+1)'(cycles_out)));
endmodule

bind field_isolate field_isolate_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .var_chars  (variant[5:3]),
  .busy       (busy),
  .done       (done),
  .a_out      (a_out),
  .g_out      (g_out),
  .h_out      (h_out),
  .cycles_out (cycles_out)
);

// File: tb/field_isolate_test.sv
module field_isolate_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  variant = '0;
  logic [47:0] a_in = '0;
  logic [2:0]  g_in = '0;
  logic [2:0]  h_in = '0;
  logic        busy, done;
  logic [47:0] a_out;
  logic [2:0]  g_out, h_out;
  logic [4:0]  cycles_out;

  int checks = 0;
  int fails = 0;
  int wd = 0;
  bit armed = 0;
  string cur_tag = "R1";

  always #4 clk = ~clk;

  field_isolate uut (
    .clk(clk), .rst(rst), .start(start), .variant(variant),
    .a_in(a_in), .g_in(g_in), .h_in(h_in),
    .busy(busy), .done(done), .a_out(a_out), .g_out(g_out),
    .h_out(h_out), .cycles_out(cycles_out)
  );

  // ---------------- behavioural reference model ----------------
  logic        m_busy, m_done;
  int          m_cnt, m_cyc, m_g, m_h, p_g;
  logic [47:0] m_a, p_a;

  function automatic logic [47:0] isolate(logic [47:0] w, int s, int len);
    logic [47:0] r = '0;
    for (int k = 0; k < len; k++) begin
      int src = (s + k) % 48;           // MSB-first numbering
      r[len - 1 - k] = w[47 - src];
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy <= 0; m_done <= 0; m_cnt <= 0; m_cyc <= 0;
      m_a <= '0; m_g <= 0; m_h <= 0; p_a <= '0; p_g <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 0; m_done <= 1; m_a <= p_a; m_g <= p_g; m_h <= 0;
        end else m_cnt <= m_cnt - 1;
      end else if (start) begin
        int nc, tr, hc, s, len;
        nc = variant / 8; tr = variant % 8;
        hc = (h_in > 5) ? 5 : int'(h_in);
        if (nc == 0) begin
          m_done <= 1; m_a <= a_in; m_g <= g_in; m_h <= h_in; m_cyc <= 0;
        end else begin
          s = g_in * 6 + hc;
          len = nc * 6 - tr;
          if (len < 0) len = 0;
          m_cyc <= nc + tr + g_in + hc;
          m_cnt <= nc + tr + g_in + hc;
          m_busy <= 1;
          p_a <= isolate(a_in, s, len);
          p_g <= (g_in + nc) % 8;
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      check("R9", "busy", 64'(busy), 64'(m_busy));
      check("R9", "done", 64'(done), 64'(m_done));
      check("R8", "cycles_out", 64'(cycles_out), 64'(m_cyc));
      check("R7", "g_out", 64'(g_out), 64'(m_g));
      check("R7", "h_out", 64'(h_out), 64'(m_h));
      check(cur_tag, "a_out", 64'(a_out), 64'(m_a));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic drive(logic [47:0] a, int g, int h, int v);
    start = 1; a_in = a; g_in = 3'(g); h_in = 3'(h); variant = 6'(v);
  endtask

  task automatic wait_done();
    while (!m_done) begin @(posedge clk); #2; end
  endtask

  task automatic run_op(logic [47:0] a, int g, int h, int v, string tag);
    @(posedge clk); #2;
    cur_tag = tag;
    drive(a, g, h, v);
    @(posedge clk); #2;
    start = 0;
    wait_done();
    @(posedge clk); #2;
  endtask

  initial begin
    @(posedge clk); armed = 1;
    repeat (3) @(posedge clk);
    #4;
    // R1: reset state
    check("R1", "reset busy", 64'(busy), 64'd0);
    check("R1", "reset done", 64'(done), 64'd0);
    check("R1", "reset a_out", 64'(a_out), 64'd0);
    check("R1", "reset cycles", 64'(cycles_out), 64'd0);
    @(posedge clk); #2; rst = 0;

    // R4 / R2: one char from bit 0
    run_op(48'hFC00_0000_0000, 0, 0, 8, "R4");
    // R2 / R3: start 15, len 16
    run_op(48'h1234_5678_9ABC, 2, 3, 8'o32, "R2");
    // R3: trim bigger than the field -> zero
    run_op(48'hFFFF_FFFF_FFFF, 1, 1, 8'o17, "R3");
    // R5: wrap from bit 46, 12 bits
    run_op(48'hC00F_F000_0003, 7, 4, 8'o20, "R5");
    // R5: long wrap, start 30, 42 bits
    run_op(48'hA5A5_5A5A_F00F, 5, 0, 8'o70, "R5");
    // R6: zero characters -> no-op
    run_op(48'hDEAD_BEEF_0123, 4, 6, 8'o05, "R6");
    // R11: h=7 clamps to 5
    run_op(48'h0000_0000_003F, 7, 7, 8'o13, "R11");
    // R7: pointer wraps: 6+5 -> 3
    run_op(48'h0F0F_0F0F_0F0F, 6, 2, 8'o51, "R7");

    // R10: start in the middle of a run is ignored
    @(posedge clk); #2; cur_tag = "R10";
    drive(48'h8000_0000_0001, 3, 2, 8'o44);
    @(posedge clk); #2; start = 0;
    @(posedge clk); #2;
    drive(48'hFFFF_0000_FFFF, 1, 0, 8'o70);
    @(posedge clk); #2; start = 0;
    wait_done();
    @(posedge clk); #2;

    // R9: start lands exactly in the done cycle
    cur_tag = "R9";
    drive(48'h1111_2222_3333, 0, 1, 8'o21);
    @(posedge clk); #2; start = 0;
    wait_done();
    drive(48'h4444_5555_6666, 2, 5, 8'o33);
    @(posedge clk); #2; start = 0;
    wait_done();
    @(posedge clk); #2;

    // mixed patterns
    for (int i = 0; i < 60; i++) begin
      logic [47:0] w;
      w = {$urandom, $urandom} ;
      run_op(w, int'($urandom % 8), int'($urandom % 8), int'($urandom % 64), "R5");
    end

    repeat (3) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule